// File: doc/BRIEF.md
# Serial-to-Register-Bus Write Bridge

This block accepts register writes from a host over a write-only SPI link and turns each completed transfer into a single-cycle write on an internal broadcast bus. All three SPI pins are sampled in the fabric clock domain through two-flop synchronizers, so the SPI clock never clocks any logic. Rising edges of the synchronized serial clock shift data into a 40-bit word while the select pin is high. When the select pin falls, the word is committed.

A commit drives a registered address, data and strobe bus. The strobe is high for one cycle, and the address and data hold their value until the next commit. Any number of register banks can listen on this bus, and each one decodes its own address window. One example bank is included. It holds four 32-bit registers at consecutive addresses starting at a parameter base and exposes their contents. The fabric clock must run at least four times faster than the SPI clock.

Top module: `spi_regwr_bridge`

## Requirements
- R1: `spi_sclk`, `spi_mosi` and `spi_sel` each pass through a two-flop synchronizer. When `spi_sel` goes low just after a rising `clk` edge, `rb_wr` is high in the cycle that follows the third later rising edge.
- R2: A bit is taken from `spi_mosi` on each detected rising edge of `spi_sclk`, but only while `spi_sel` is high. Bits enter the least significant end, so the first bit sent ends up most significant.
- R3: A frame is 40 bits. Bits 39..32 (the first 8 sent) form `rb_addr`, and bits 31..0 (the next 32) form `rb_data`.
- R4: When more than 40 bits arrive within one select period, only the last 40 bits reach the bus.
- R5: The word is cleared at every commit and at reset. A frame of fewer than 40 bits therefore lands in the low bits, and the bits above it are zero.
- R6: Each falling edge of `spi_sel` gives exactly one `rb_wr` pulse of one cycle. `rb_addr` and `rb_data` keep their value from one commit to the next.
- R7: Rising edges of `spi_sclk` while `spi_sel` is low change nothing.
- R8: A bus write to address BANK_BASE+k, for k from 0 to 3, loads `bank_q[32k+31:32k]` at the next rising edge.
- R9: A bus write to any address outside BANK_BASE..BANK_BASE+3 leaves all bank registers unchanged. This includes addresses just below the base.
- R10: While `rst_n` is low, the bus outputs, the shift word and the bank registers are zero, and no strobe is produced, even if a whole frame is sent. Reset clears asynchronously and releases on the second rising `clk` edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, asynchronous |
| spi_mosi | input | 1 | SPI serial data from host |
| spi_sel | input | 1 | Transfer select, high during a frame |
| rb_wr | output | 1 | One-cycle write strobe on the register bus |
| rb_addr | output | ADDR_W (8) | Register bus address |
| rb_data | output | DATA_W (32) | Register bus data |
| bank_q | output | NREGS*DATA_W (128) | Contents of the example bank registers |

## Verification
Exact 40-bit frames are aimed at each of the four bank addresses, with data patterns that tell apart bit order and field boundaries. Further exact frames go to addresses just above and just below the window and to address zero, which separates the bus strobe (always present) from the bank decode (only in range). Overlong and short frames show whether the word keeps the last 40 bits and whether it is cleared between frames. Serial clock toggles with select low, and a frame sent during reset, show that nothing leaks outside a valid select period. A reset in the middle of the run shows that all stored state is cleared.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  localparam int DEF_ADDR_W  = 8;
  localparam int DEF_DATA_W  = 32;
  localparam int DEF_NREGS   = 4;
  localparam int DEF_STAGES  = 2;
  localparam int DEF_BASE    = 16;

  // pin slots inside the synchronizer vector
  localparam int PIN_SCLK  = 0;
  localparam int PIN_MOSI  = 1;
  localparam int PIN_SEL   = 2;
  localparam int PIN_COUNT = 3;
endpackage

// File: rtl/bridge_rst_sync.sv
module bridge_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/bridge_pin_sync.sv
module bridge_pin_sync #(
  parameter int N_PINS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_a,
  output logic [N_PINS-1:0] pin_s
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_n;

    always_comb begin
      ff_n = {ff_q[STAGES-2:0], pin_a[p]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '0;
      else        ff_q <= ff_n;
    end

    assign pin_s[p] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/bridge_frame_shift.sv
module bridge_frame_shift #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               mosi_s,
  input  logic               sel_s,
  output logic               commit,
  output logic [FRAME_W-1:0] word
);
  logic               sclk_d;
  logic               sel_d;
  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] sh_n;
  logic               sclk_rise;
  logic               sel_fall;
  logic               take_bit;
  logic               sh_en;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_d;
    sel_fall  = sel_d & ~sel_s;
    take_bit  = sclk_rise & sel_s;
    sh_en     = sel_fall | take_bit;
    if (sel_fall) sh_n = '0;
    else          sh_n = {sh_q[FRAME_W-2:0], mosi_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_n;
  end

  assign commit = sel_fall;
  assign word   = sh_q;
endmodule

// File: rtl/bridge_bus_drive.sv
module bridge_bus_drive #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int FRAME_W = ADDR_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [FRAME_W-1:0] word,
  output logic               rb_wr,
  output logic [ADDR_W-1:0]  rb_addr,
  output logic [DATA_W-1:0]  rb_data
);
  logic              wr_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;

  always_comb begin
    wr_n   = commit;
    addr_n = word[FRAME_W-1 -: ADDR_W];
    data_n = word[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_wr <= 1'b0;
    else        rb_wr <= wr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_addr <= '0;
      rb_data <= '0;
    end else if (commit) begin
      rb_addr <= addr_n;
      rb_data <= data_n;
    end
  end
endmodule

// File: rtl/bridge_reg_bank.sv
module bridge_reg_bank #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NREGS  = 4,
  parameter int BASE   = 16,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rb_wr,
  input  logic [ADDR_W-1:0]       rb_addr,
  input  logic [DATA_W-1:0]       rb_data,
  output logic [NREGS*DATA_W-1:0] bank_q
);
  logic [ADDR_W-1:0] offset;
  logic              in_win;

  always_comb begin
    offset = rb_addr - ADDR_W'(BASE);
    in_win = rb_wr && (offset < ADDR_W'(NREGS));
  end

  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    logic              r_ld;

    always_comb begin
      r_ld = in_win && (offset[IDX_W-1:0] == IDX_W'(k));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r_q <= '0;
      else if (r_ld) r_q <= rb_data;
    end

    assign bank_q[k*DATA_W +: DATA_W] = r_q;
  end
endmodule

// File: rtl/spi_regwr_bridge.sv
module spi_regwr_bridge
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int DATA_W    = DEF_DATA_W,
  parameter int NREGS     = DEF_NREGS,
  parameter int BANK_BASE = DEF_BASE,
  parameter int STAGES    = DEF_STAGES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_mosi,
  input  logic                    spi_sel,
  output logic                    rb_wr,
  output logic [ADDR_W-1:0]       rb_addr,
  output logic [DATA_W-1:0]       rb_data,
  output logic [NREGS*DATA_W-1:0] bank_q
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  logic                 rst_int_n;
  logic [PIN_COUNT-1:0] pins_a;
  logic [PIN_COUNT-1:0] pins_s;
  logic                 commit;
  logic [FRAME_W-1:0]   word;

  always_comb begin
    pins_a           = '0;
    pins_a[PIN_SCLK] = spi_sclk;
    pins_a[PIN_MOSI] = spi_mosi;
    pins_a[PIN_SEL]  = spi_sel;
  end

  bridge_rst_sync #(.STAGES(STAGES)) i_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  bridge_pin_sync #(.N_PINS(PIN_COUNT), .STAGES(STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin_a (pins_a),
    .pin_s (pins_s)
  );

  bridge_frame_shift #(.FRAME_W(FRAME_W)) i_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sclk_s (pins_s[PIN_SCLK]),
    .mosi_s (pins_s[PIN_MOSI]),
    .sel_s  (pins_s[PIN_SEL]),
    .commit (commit),
    .word   (word)
  );

  bridge_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .commit  (commit),
    .word    (word),
    .rb_wr   (rb_wr),
    .rb_addr (rb_addr),
    .rb_data (rb_data)
  );

  bridge_reg_bank #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NREGS  (NREGS),
    .BASE   (BANK_BASE)
  ) i_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rb_wr   (rb_wr),
    .rb_addr (rb_addr),
    .rb_data (rb_data),
    .bank_q  (bank_q)
  );
endmodule

// File: rtl/spi_regwr_bridge_chk.sv
module spi_regwr_bridge_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NREGS     = 4,
  parameter int BANK_BASE = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    spi_sel,
  input logic                    rb_wr,
  input logic [ADDR_W-1:0]       rb_addr,
  input logic [DATA_W-1:0]       rb_data,
  input logic [NREGS*DATA_W-1:0] bank_q
);
  logic [ADDR_W-1:0] offs;
  assign offs = rb_addr - ADDR_W'(BANK_BASE);

  // R6: strobe lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rb_wr |=> !rb_wr);

  // R6: bus address and data hold between commits
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_wr |-> ($stable(rb_addr) && $stable(rb_data)));

  // R1: a strobe is never produced while the select pin stays high
  a_r1_no_wr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_sel) && spi_sel) |-> !rb_wr);

  // R9: out-of-window writes and idle cycles keep the bank
  a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_wr || (offs >= ADDR_W'(NREGS))) |=> $stable(bank_q));

  // R8: in-window write loads the addressed register
  for (genvar k = 0; k < NREGS; k++) begin : g_ld
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_wr && rb_addr == ADDR_W'(BANK_BASE + k))
        |=> (bank_q[k*DATA_W +: DATA_W] == $past(rb_data)));
  end

  // R10: quiet and cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_quiet: assert (!rb_wr && bank_q == '0 && rb_addr == '0 && rb_data == '0);
    end
  end
endmodule

bind spi_regwr_bridge spi_regwr_bridge_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NREGS     (NREGS),
  .BANK_BASE (BANK_BASE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .spi_sel (spi_sel),
  .rb_wr   (rb_wr),
  .rb_addr (rb_addr),
  .rb_data (rb_data),
  .bank_q  (bank_q)
);

// File: tb/test_spi_regwr_bridge.sv
module test_spi_regwr_bridge;
  localparam real CLK_PERIOD = 10.0;
  localparam int  BASE       = 16;
  localparam int  HALF       = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         spi_sclk, spi_mosi, spi_sel;
  logic         rb_wr;
  logic [7:0]   rb_addr;
  logic [31:0]  rb_data;
  logic [127:0] bank_q;

  spi_regwr_bridge i_spi_regwr_bridge (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_sel(spi_sel), .rb_wr(rb_wr), .rb_addr(rb_addr), .rb_data(rb_data),
    .bank_q(bank_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int at; logic [39:0] w; } exp_t;
  exp_t        q_exp[$];
  logic [31:0] mreg [4];
  logic [7:0]  m_addr;
  logic [31:0] m_data;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  string       req_tag = "R10";
  bit          done = 0;

  task automatic check(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req_tag, what, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle reference comparison
  always begin
    @(posedge clk);
    cyc++;
    #(CLK_PERIOD*0.25);
    if (!done) begin
      bit exp_wr;
      if (!rst_n) begin
        q_exp.delete();
        m_addr = '0; m_data = '0;
        for (int i = 0; i < 4; i++) mreg[i] = '0;
      end
      exp_wr = 1'b0;
      if (q_exp.size() > 0 && q_exp[0].at == cyc) begin
        exp_wr = 1'b1;
        m_addr = q_exp[0].w[39:32];
        m_data = q_exp[0].w[31:0];
        void'(q_exp.pop_front());
      end
      check(rb_wr == exp_wr, "R1/R6 rb_wr", 128'(rb_wr), 128'(exp_wr));
      check(rb_addr == m_addr, "R3/R6 rb_addr", 128'(rb_addr), 128'(m_addr));
      check(rb_data == m_data, "R3/R6 rb_data", 128'(rb_data), 128'(m_data));
      for (int i = 0; i < 4; i++)
        check(bank_q[i*32 +: 32] == mreg[i], "R8/R9 bank reg", 128'(bank_q[i*32 +: 32]), 128'(mreg[i]));
      if (exp_wr && m_addr >= 8'(BASE) && m_addr < 8'(BASE + 4))
        mreg[m_addr - 8'(BASE)] = m_data;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: bits shift on serial clock rise while select is high
  task automatic send(input logic [63:0] v, input int nbits);
    logic [39:0] acc;
    acc = '0;
    @(negedge clk);
    spi_sel = 1'b1;
    for (int i = nbits - 1; i >= 0; i--) begin
      spi_mosi = v[i];
      spi_sclk = 1'b0;
      wait_n(HALF);
      spi_sclk = 1'b1;
      acc = {acc[38:0], v[i]};
      wait_n(HALF);
    end
    spi_sclk = 1'b0;
    wait_n(HALF);
    spi_sel = 1'b0;
    if (rst_n) q_exp.push_back('{at: cyc + 3, w: acc});
    wait_n(10);
  endtask

  // R7: serial clock activity with select low
  task automatic idle_toggle(input int n);
    spi_mosi = 1'b1;
    for (int i = 0; i < n; i++) begin
      spi_sclk = 1'b1; wait_n(HALF);
      spi_sclk = 1'b0; wait_n(HALF);
    end
    wait_n(4);
  endtask

  initial begin
    spi_sclk = 1'b0; spi_mosi = 1'b0; spi_sel = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    // R10: a full frame during reset produces nothing
    req_tag = "R10";
    send(64'h10_DEADBEEF, 40);
    @(negedge clk) rst_n = 1'b1;
    wait_n(6);

    req_tag = "R3";
    send(64'h10_DEADBEEF, 40);
    req_tag = "R8";
    send(64'h13_12345678, 40);
    send(64'h11_A5A55A5A, 40);
    send(64'h12_FFFFFFFF, 40);
    send(64'h10_00000001, 40);
    req_tag = "R9";
    send(64'h14_0BAD0BAD, 40);
    send(64'h0F_CAFEF00D, 40);
    send(64'h00_80000000, 40);
    req_tag = "R4";
    send(64'hAB_12_0000FFFF, 48);
    send(64'h5A5A_13_C3C3C3C3, 56);
    req_tag = "R7";
    idle_toggle(6);
    req_tag = "R5";
    send(64'hABC, 12);
    send(64'h8_1234F, 20);
    send(64'h11_00000000_FF, 48);
    send(64'h3, 2);
    req_tag = "R6";
    send(64'h13_5555AAAA, 40);
    wait_n(20);

    // R10: reset mid-run clears bus and bank
    req_tag = "R10";
    @(negedge clk) rst_n = 1'b0;
    wait_n(4);
    @(negedge clk) rst_n = 1'b1;
    wait_n(6);
    req_tag = "R8";
    send(64'h12_600DF00D, 40);
    wait_n(20);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule